// File: doc/BRIEF.md
# Reservation Station with Result-Bus Wakeup

This block holds a small pool of station entries in front of one functional unit of a dynamically scheduled core. An operation is accepted on the issue port with a destination register and two source registers. The block keeps a rename table and a register file. Each source is looked up there and turned either into a value or into the tag of the station entry that will produce it. The destination register is then redirected to the tag of the entry just allocated, so later consumers wait on that entry and not on the stale register.

The functional unit sits outside the block and returns its results on a single result bus as a (tag, value) pair. Every entry waiting on that tag takes the value in the same cycle. The producing entry is released. The register file is written only if the rename table still points the register at that tag. When an entry holds both operand values it is ready. Among ready entries, the one with the lowest index is sent to the functional unit, and at most one is sent per cycle.

Each entry is a four-state machine. FREE goes to WAIT on allocation when an operand is missing, or to READY when both operands are present (alloc). WAIT goes to READY once both operands are present after a bus capture (wakeup). READY goes to EXEC when the entry is chosen for dispatch (select). EXEC goes back to FREE when its own tag appears on the result bus (retire). The tag of an entry is its index.

Top module: `rs_station`

## Requirements
- R1: `iss_ready` is low exactly when all entries are occupied. An issue presented while it is low is ignored: no entry, no rename and no later dispatch comes from it.
- R2: A source whose register is not pending is copied from the register file. After reset, register i holds 0x0100 + i.
- R3: A source whose register is pending stores the producer's tag. The entry is not dispatched before that tag is broadcast.
- R4: At issue, the destination register is renamed to the allocated entry, which is the lowest-index FREE entry. Later readers of that register wait on the new tag.
- R5: An entry is dispatch-eligible only when both operands hold values. An entry with one pending operand stays waiting.
- R6: A broadcast is captured by every entry waiting on that tag, all in the same cycle. Those entries are dispatch-eligible from the cycle after the broadcast.
- R7: A broadcast frees the entry whose tag it carries, and that entry can be allocated again.
- R8: A broadcast writes the register file and clears the pending mark only when the register is still mapped to the broadcast tag. A stale broadcast changes neither.
- R9: A source issued in the same cycle as its producer's broadcast takes the broadcast value directly and does not wait.
- R10: When several entries are ready, the lowest index is dispatched first, one per cycle. `dsp_valid` is combinational from the entry states, and a dispatched entry moves to EXEC in the next cycle and is not sent again.
- R11: After reset all entries are FREE, `iss_ready` is high, `dsp_valid` is low and no register is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request this cycle |
| iss_op | input | OPW | Operation code carried to the functional unit |
| iss_dst | input | log2(NUM_ARCH) | Destination architectural register |
| iss_src_a | input | log2(NUM_ARCH) | First source register |
| iss_src_b | input | log2(NUM_ARCH) | Second source register |
| iss_ready | output | 1 | A free entry exists |
| bc_valid | input | 1 | Result bus carries a result |
| bc_tag | input | log2(NUM_ENT) | Tag of the producing entry |
| bc_value | input | DW | Result value |
| dsp_valid | output | 1 | An entry is dispatched this cycle |
| dsp_tag | output | log2(NUM_ENT) | Tag of the dispatched entry |
| dsp_op | output | OPW | Operation of the dispatched entry |
| dsp_a | output | DW | First operand value |
| dsp_b | output | DW | Second operand value |

## Verification
The hardest situation to reach is a stale broadcast. This needs two writers of the same register in flight, with the older one finishing after the younger has taken the rename mapping. The stimulus issues both writers back to back and holds their results. It then issues a reader of the register that must wait on the younger tag. It releases the older result first and shows that the reader stays asleep. Finally it reads the register again to show that the register file kept the younger value. A second hard case is a source lookup that coincides with its producer's broadcast: the bench drives the issue and the result bus in the same cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2,
        ST_EXEC  = 2'd3
    } ent_state_e;
endpackage

// File: rtl/rs_pick.sv
// Lowest-index priority picker (N >= 2).
module rs_pick #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  grant
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
                grant = N'(1) << i;
            end
        end
    end
endmodule

// File: rtl/rs_rename.sv
// Rename table plus architectural register file.
module rs_rename #(
    parameter int NUM_ARCH = 8,
    parameter int DW       = 16,
    parameter int TW       = 2,
    parameter int RF_BASE  = 256,
    localparam int AW = $clog2(NUM_ARCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] sa_reg,
    input  logic [AW-1:0] sb_reg,
    output logic          sa_rdy,
    output logic [DW-1:0] sa_val,
    output logic [TW-1:0] sa_tag,
    output logic          sb_rdy,
    output logic [DW-1:0] sb_val,
    output logic [TW-1:0] sb_tag,
    input  logic          upd_en,
    input  logic [AW-1:0] upd_reg,
    input  logic [TW-1:0] upd_tag,
    input  logic          bc_valid,
    input  logic [TW-1:0] bc_tag,
    input  logic [DW-1:0] bc_value,
    input  logic [AW-1:0] bc_dst
);
    logic          pend_q [NUM_ARCH];
    logic [TW-1:0] tag_q  [NUM_ARCH];
    logic [DW-1:0] rf_q   [NUM_ARCH];
    logic          bc_match;

    assign bc_match = bc_valid && pend_q[bc_dst] && (tag_q[bc_dst] == bc_tag);

    // Source lookup with same-cycle bypass from the result bus
    always_comb begin
        sa_tag = tag_q[sa_reg];
        sb_tag = tag_q[sb_reg];
        if (!pend_q[sa_reg]) begin
            sa_rdy = 1'b1; sa_val = rf_q[sa_reg];
        end else if (bc_valid && tag_q[sa_reg] == bc_tag) begin
            sa_rdy = 1'b1; sa_val = bc_value;
        end else begin
            sa_rdy = 1'b0; sa_val = '0;
        end
        if (!pend_q[sb_reg]) begin
            sb_rdy = 1'b1; sb_val = rf_q[sb_reg];
        end else if (bc_valid && tag_q[sb_reg] == bc_tag) begin
            sb_rdy = 1'b1; sb_val = bc_value;
        end else begin
            sb_rdy = 1'b0; sb_val = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) begin
                pend_q[i] <= 1'b0;
                tag_q[i]  <= '0;
                rf_q[i]   <= DW'(RF_BASE + i);
            end
        end else begin
            if (bc_match) begin
                rf_q[bc_dst]   <= bc_value;
                pend_q[bc_dst] <= 1'b0;
            end
            if (upd_en) begin
                pend_q[upd_reg] <= 1'b1;
                tag_q[upd_reg]  <= upd_tag;
            end
        end
    end

    // R8: a matching broadcast leaves the register no longer pending
    a_r8_mapping_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_match && !(upd_en && upd_reg == bc_dst)) |=> !pend_q[$past(bc_dst)]);
endmodule

// File: rtl/rs_entry.sv
// One station entry: FREE -> WAIT/READY -> EXEC -> FREE.
module rs_entry
    import rs_pkg::*;
#(
    parameter int DW     = 16,
    parameter int OPW    = 4,
    parameter int AW     = 3,
    parameter int TW     = 2,
    parameter int MY_TAG = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic [OPW-1:0] in_op,
    input  logic [AW-1:0] in_dst,
    input  logic          in_a_rdy,
    input  logic [DW-1:0] in_a_val,
    input  logic [TW-1:0] in_a_tag,
    input  logic          in_b_rdy,
    input  logic [DW-1:0] in_b_val,
    input  logic [TW-1:0] in_b_tag,
    input  logic          sel,
    input  logic          bc_valid,
    input  logic [TW-1:0] bc_tag,
    input  logic [DW-1:0] bc_value,
    output ent_state_e    st,
    output logic [OPW-1:0] op,
    output logic [AW-1:0] dst,
    output logic [DW-1:0] a_val,
    output logic [DW-1:0] b_val
);
    ent_state_e     st_q, st_n;
    logic           a_rdy_q, b_rdy_q;
    logic [DW-1:0]  a_val_q, b_val_q;
    logic [TW-1:0]  a_tag_q, b_tag_q;
    logic [OPW-1:0] op_q;
    logic [AW-1:0]  dst_q;
    logic           hit_a, hit_b, own_done;

    assign hit_a    = (st_q == ST_WAIT) && bc_valid && !a_rdy_q && (a_tag_q == bc_tag);
    assign hit_b    = (st_q == ST_WAIT) && bc_valid && !b_rdy_q && (b_tag_q == bc_tag);
    assign own_done = bc_valid && (bc_tag == TW'(MY_TAG));

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_FREE:  if (alloc) st_n = (in_a_rdy && in_b_rdy) ? ST_READY : ST_WAIT;
            ST_WAIT:  if ((a_rdy_q || hit_a) && (b_rdy_q || hit_b)) st_n = ST_READY;
            ST_READY: if (sel) st_n = ST_EXEC;
            ST_EXEC:  if (own_done) st_n = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_FREE;
        else        st_q <= st_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rdy_q <= 1'b0; b_rdy_q <= 1'b0;
            a_val_q <= '0;   b_val_q <= '0;
            a_tag_q <= '0;   b_tag_q <= '0;
            op_q    <= '0;   dst_q   <= '0;
        end else if (alloc && st_q == ST_FREE) begin
            a_rdy_q <= in_a_rdy; a_val_q <= in_a_val; a_tag_q <= in_a_tag;
            b_rdy_q <= in_b_rdy; b_val_q <= in_b_val; b_tag_q <= in_b_tag;
            op_q    <= in_op;    dst_q   <= in_dst;
        end else begin
            if (hit_a) begin a_rdy_q <= 1'b1; a_val_q <= bc_value; end
            if (hit_b) begin b_rdy_q <= 1'b1; b_val_q <= bc_value; end
        end
    end

    assign st    = st_q;
    assign op    = op_q;
    assign dst   = dst_q;
    assign a_val = a_val_q;
    assign b_val = b_val_q;

    // R5: a ready entry holds both operand values
    a_r5_ready_has_operands: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READY) |-> (a_rdy_q && b_rdy_q));
    // R6: a waiting operand takes the broadcast value
    a_r6_capture_a: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a |=> (a_rdy_q && a_val_q == $past(bc_value)));
    // R7: own-tag broadcast releases the entry
    a_r7_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EXEC && own_done) |=> (st_q == ST_FREE));
    // R10: a selected entry leaves the ready pool
    a_r10_select_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READY && sel) |=> (st_q == ST_EXEC));
endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int NUM_ENT  = 4,
    parameter int NUM_ARCH = 8,
    parameter int DW       = 16,
    parameter int OPW      = 4,
    localparam int TW = $clog2(NUM_ENT),
    localparam int AW = $clog2(NUM_ARCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           iss_valid,
    input  logic [OPW-1:0] iss_op,
    input  logic [AW-1:0]  iss_dst,
    input  logic [AW-1:0]  iss_src_a,
    input  logic [AW-1:0]  iss_src_b,
    output logic           iss_ready,
    input  logic           bc_valid,
    input  logic [TW-1:0]  bc_tag,
    input  logic [DW-1:0]  bc_value,
    output logic           dsp_valid,
    output logic [TW-1:0]  dsp_tag,
    output logic [OPW-1:0] dsp_op,
    output logic [DW-1:0]  dsp_a,
    output logic [DW-1:0]  dsp_b
);
    ent_state_e     ent_st  [NUM_ENT];
    logic [OPW-1:0] ent_op  [NUM_ENT];
    logic [AW-1:0]  ent_dst [NUM_ENT];
    logic [DW-1:0]  ent_a   [NUM_ENT];
    logic [DW-1:0]  ent_b   [NUM_ENT];
    logic [NUM_ENT-1:0] free_vec, ready_vec, free_gnt, sel_vec, alloc_vec;
    logic [TW-1:0]  free_idx;
    logic           free_found, issue_fire;
    logic           sa_rdy, sb_rdy;
    logic [DW-1:0]  sa_val, sb_val;
    logic [TW-1:0]  sa_tag, sb_tag;

    generate
        for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
            assign free_vec[g]  = (ent_st[g] == ST_FREE);
            assign ready_vec[g] = (ent_st[g] == ST_READY);
            rs_entry #(.DW(DW), .OPW(OPW), .AW(AW), .TW(TW), .MY_TAG(g)) u_ent (
                .clk(clk), .rst_n(rst_n), .alloc(alloc_vec[g]),
                .in_op(iss_op), .in_dst(iss_dst),
                .in_a_rdy(sa_rdy), .in_a_val(sa_val), .in_a_tag(sa_tag),
                .in_b_rdy(sb_rdy), .in_b_val(sb_val), .in_b_tag(sb_tag),
                .sel(sel_vec[g]), .bc_valid(bc_valid), .bc_tag(bc_tag),
                .bc_value(bc_value), .st(ent_st[g]), .op(ent_op[g]),
                .dst(ent_dst[g]), .a_val(ent_a[g]), .b_val(ent_b[g])
            );
        end
    endgenerate

    rs_pick #(.N(NUM_ENT)) u_free_pick (
        .req(free_vec), .found(free_found), .idx(free_idx), .grant(free_gnt)
    );
    rs_pick #(.N(NUM_ENT)) u_disp_pick (
        .req(ready_vec), .found(dsp_valid), .idx(dsp_tag), .grant(sel_vec)
    );

    assign iss_ready  = free_found;
    assign issue_fire = iss_valid && free_found;
    assign alloc_vec  = issue_fire ? free_gnt : '0;

    rs_rename #(.NUM_ARCH(NUM_ARCH), .DW(DW), .TW(TW)) u_rename (
        .clk(clk), .rst_n(rst_n),
        .sa_reg(iss_src_a), .sb_reg(iss_src_b),
        .sa_rdy(sa_rdy), .sa_val(sa_val), .sa_tag(sa_tag),
        .sb_rdy(sb_rdy), .sb_val(sb_val), .sb_tag(sb_tag),
        .upd_en(issue_fire), .upd_reg(iss_dst), .upd_tag(free_idx),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
        .bc_dst(ent_dst[bc_tag])
    );

    assign dsp_op = ent_op[dsp_tag];
    assign dsp_a  = ent_a[dsp_tag];
    assign dsp_b  = ent_b[dsp_tag];

    // R10: at most one entry selected, and the one reported is ready
    a_r10_single_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_vec) && (!dsp_valid || ready_vec[dsp_tag]));
    // R1: no allocation happens without a free entry
    a_r1_no_alloc_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (free_vec == '0) |-> (alloc_vec == '0));
endmodule

// File: tb/rs_station_bench.sv
module rs_station_bench;
    localparam int NUM_ENT = 4, NUM_ARCH = 8, DW = 16, OPW = 4;
    localparam int TW = $clog2(NUM_ENT), AW = $clog2(NUM_ARCH);

    logic clk = 1'b0, rst_n = 1'b0;
    logic iss_valid = 1'b0, bc_valid = 1'b0;
    logic [OPW-1:0] iss_op = '0;
    logic [AW-1:0]  iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
    logic [TW-1:0]  bc_tag = '0;
    logic [DW-1:0]  bc_value = '0;
    logic iss_ready, dsp_valid;
    logic [TW-1:0]  dsp_tag;
    logic [OPW-1:0] dsp_op;
    logic [DW-1:0]  dsp_a, dsp_b;

    int errors = 0, checks = 0;
    logic [TW+OPW+2*DW-1:0] exp_q [$];
    string req_q [$];

    always #10 clk = ~clk;

    rs_station #(.NUM_ENT(NUM_ENT), .NUM_ARCH(NUM_ARCH), .DW(DW), .OPW(OPW)) u_rs_station (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_dst(iss_dst), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .iss_ready(iss_ready), .bc_valid(bc_valid), .bc_tag(bc_tag),
        .bc_value(bc_value), .dsp_valid(dsp_valid), .dsp_tag(dsp_tag),
        .dsp_op(dsp_op), .dsp_a(dsp_a), .dsp_b(dsp_b)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_dsp(input int tag, input int op, input int a, input int b, input string req);
        exp_q.push_back({TW'(tag), OPW'(op), DW'(a), DW'(b)});
        req_q.push_back(req);
    endtask

    task automatic issue(input int op, input int dst, input int sa, input int sb);
        iss_valid = 1'b1; iss_op = OPW'(op); iss_dst = AW'(dst);
        iss_src_a = AW'(sa); iss_src_b = AW'(sb);
    endtask

    task automatic bcast(input int tag, input int val);
        bc_valid = 1'b1; bc_tag = TW'(tag); bc_value = DW'(val);
    endtask

    task automatic step();
        @(posedge clk); #1;
        iss_valid = 1'b0; bc_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Monitor: every dispatch is compared against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && dsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected dispatch", {dsp_tag, dsp_op, dsp_a, dsp_b}, 0);
            end else begin
                logic [TW+OPW+2*DW-1:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk({dsp_tag, dsp_op, dsp_a, dsp_b} == e, r, {dsp_tag, dsp_op, dsp_a, dsp_b}, e);
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(iss_ready === 1'b1, "R11 iss_ready after reset", iss_ready, 1);
        chk(dsp_valid === 1'b0, "R11 dsp_valid after reset", dsp_valid, 0);
        #1;
        // R2: both sources ready from reset register file
        expect_dsp(0, 1, 16'h0102, 16'h0103, "R2 ready sources");
        issue(1, 1, 2, 3); step(); idle(1);
        // R3: two consumers of r1 wait on tag 0
        issue(2, 4, 1, 5); step();
        issue(3, 6, 1, 1); step();
        idle(2);
        @(negedge clk);
        chk(dsp_valid === 1'b0, "R3 R5 waiting entries not dispatched", dsp_valid, 0);
        #1;
        // R6/R10: one broadcast wakes both; lowest index first
        expect_dsp(1, 2, 16'hAAAA, 16'h0105, "R6 R10 first woken entry");
        expect_dsp(2, 3, 16'hAAAA, 16'hAAAA, "R6 R10 second woken entry");
        bcast(0, 16'hAAAA); step(); idle(2);
        // R7/R8: entry 0 reused, r1 now holds broadcast value
        expect_dsp(0, 4, 16'hAAAA, 16'h0100, "R7 R8 freed entry reused, rf updated");
        issue(4, 7, 1, 0); step();
        expect_dsp(3, 5, 16'h0100, 16'h0100, "R4 lowest free entry");
        issue(5, 3, 0, 0); step();
        @(negedge clk);
        chk(iss_ready === 1'b0, "R1 full pool stalls issue", iss_ready, 0);
        #1;
        idle(1);
        // R1: issue while full is ignored (would rename r2)
        issue(9, 2, 0, 0); step(); idle(2);
        bcast(3, 16'h3333); step();
        @(negedge clk);
        chk(iss_ready === 1'b1, "R7 broadcast frees entry", iss_ready, 1);
        #1;
        bcast(1, 16'h1111); step();
        bcast(2, 16'h2222); step();
        bcast(0, 16'h7777); step();
        expect_dsp(0, 6, 16'h0102, 16'h3333, "R1 ignored issue left r2 unrenamed");
        issue(6, 5, 2, 3); step(); idle(1);
        // R4/R8: younger writer of r5 takes the mapping
        expect_dsp(1, 7, 16'h0100, 16'h0100, "R4 second writer");
        issue(7, 5, 0, 0); step(); idle(1);
        issue(8, 6, 5, 0); step(); idle(1);
        bcast(0, 16'h5555); step(); idle(1);
        @(negedge clk);
        chk(dsp_valid === 1'b0, "R4 R8 stale broadcast does not wake reader", dsp_valid, 0);
        #1;
        expect_dsp(2, 8, 16'h6666, 16'h0100, "R4 reader woken by younger tag");
        bcast(1, 16'h6666); step(); idle(1);
        expect_dsp(0, 9, 16'h6666, 16'h1111, "R8 stale broadcast did not write rf");
        issue(9, 7, 5, 4); step(); idle(1);
        // R9: issue reading r6 while its producer (tag 2) broadcasts
        expect_dsp(1, 10, 16'h9999, 16'h9999, "R9 same-cycle bypass");
        issue(10, 1, 6, 6); bcast(2, 16'h9999); step(); idle(2);
        chk(exp_q.size() == 0, "R10 all expected dispatches seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule